// File: doc/BRIEF.md
# Register-Mapped Reconfiguration Port Bridge

This block lets software reach the dynamic reconfiguration port of a clock-synthesis primitive through three 32-bit registers. Software launches a port transaction with a single write to a command register. That word carries the launch bit, the direction, the 7-bit port register address and the 16-bit write data. The bridge drives one enable strobe and holds address, data and direction until the port answers with its ready pulse. A status register reports whether a transaction is still outstanding and gives the data returned by the last completed read. Any masking is done by software as a read followed by a write.

A separate control register drives the primitive's active-high reset and its output-enable line. Register reads take one cycle: `reg_rdata` is loaded on the clock edge that samples `reg_rd` and holds until the next read. The transaction sequencer has three states. `ST_IDLE` moves to `ST_ISSUE` on LAUNCH, which is an accepted command. `ST_ISSUE` is the single strobe cycle. It moves to `ST_WAIT` on STROBED, or straight back to `ST_IDLE` on COMPLETE if ready is already high. `ST_WAIT` returns to `ST_IDLE` on COMPLETE, which is the cycle ready is seen.

Top module: `drp_cfg_bridge`

## Requirements
- R1: After reset the status word reads 0, `drp_en` is low, `prim_rst` is high, `prim_oe` is low and the control register at 0x40 reads 0.
- R2: A write to byte offset 0x70 with bit 29 set, made while idle, raises `drp_en` for exactly one cycle: the cycle after the write. In that cycle `drp_we` is the inverse of bit 28 (1 = port write), `drp_addr` is bits 22:16 and `drp_di` is bits 15:0.
- R3: `drp_addr`, `drp_di` and `drp_we` stay unchanged from the strobe cycle until the cycle in which `drp_rdy` is seen.
- R4: Status bit 16 (busy) at offset 0x74 is 1 from the cycle after an accepted command until the edge that samples `drp_rdy` high, and 0 from then on.
- R5: On completion of a port read, `drp_do` is captured into status bits 15:0 on the same edge that clears busy. A completed port write leaves status bits 15:0 unchanged.
- R6: A command write made while busy is 1 is ignored. This includes a write made in the same cycle as `drp_rdy`. No strobe follows, and the held address and data do not change.
- R7: A write to 0x70 with bit 29 clear starts no transaction. Bits 31:30 and 27:23 of the command word have no effect.
- R8: At offset 0x40, bit 0 set releases the primitive reset (`prim_rst` = not bit 0) and bit 1 drives `prim_oe`. Both take effect the cycle after the write. The register reads back with those two bits in 1:0 and zeros above.
- R9: A `drp_rdy` pulse while idle changes neither busy nor the read data.
- R10: Reads of 0x70 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| drp_en | output | 1 | Port transaction strobe |
| drp_we | output | 1 | Port write enable |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port ready pulse |
| prim_rst | output | 1 | Primitive reset, active high |
| prim_oe | output | 1 | Primitive output enable |

## Verification
Two events can fall in the same cycle: a new command write and the ready pulse that completes the current transaction. The bench sets the port model's latency so that ready rises exactly in the cycle it drives the second command. The result is judged at the ports. No second strobe may appear, busy must then read 0, and the read data must come from the first transaction. A ready pulse while idle, and a command written in the middle of a long transaction, are checked the same way.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
    localparam int OFF_RSTCTL = 'h40;
    localparam int OFF_CMD    = 'h70;
    localparam int OFF_STAT   = 'h74;

    localparam int CMD_GO_BIT   = 29;
    localparam int CMD_RD_BIT   = 28;
    localparam int CMD_ADDR_LSB = 16;
    localparam int STAT_BUSY_BIT = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } drp_state_e;
endpackage

// File: rtl/drp_reg_decode.sv
module drp_reg_decode
    import drp_bridge_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int DRP_AW = 7,
    parameter int DRP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    input  logic [DRP_DW-1:0] rd_data,
    input  logic [1:0]        rstctl_bits,
    output logic              cmd_go,
    output logic              cmd_read,
    output logic [DRP_AW-1:0] cmd_addr,
    output logic [DRP_DW-1:0] cmd_data,
    output logic              rstctl_wr,
    output logic [31:0]       reg_rdata
);
    localparam logic [REG_AW-1:0] A_RST  = REG_AW'(OFF_RSTCTL);
    localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(OFF_CMD);
    localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFF_STAT);

    logic [31:0] stat_word;
    logic [31:0] rd_mux;

    always_comb begin
        cmd_go    = reg_wr && (reg_addr == A_CMD) && reg_wdata[CMD_GO_BIT];
        cmd_read  = reg_wdata[CMD_RD_BIT];
        cmd_addr  = reg_wdata[CMD_ADDR_LSB +: DRP_AW];
        cmd_data  = reg_wdata[DRP_DW-1:0];
        rstctl_wr = reg_wr && (reg_addr == A_RST);
    end

    always_comb begin
        stat_word = '0;
        stat_word[DRP_DW-1:0]    = rd_data;
        stat_word[STAT_BUSY_BIT] = busy;
        if (reg_addr == A_STAT)
            rd_mux = stat_word;
        else if (reg_addr == A_RST)
            rd_mux = {30'd0, rstctl_bits};
        else
            rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    p_cmd_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CMD) |=> (reg_rdata == 32'd0));
endmodule

// File: rtl/drp_txn_fsm.sv
module drp_txn_fsm
    import drp_bridge_pkg::*;
#(
    parameter int DRP_AW = 7,
    parameter int DRP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_read,
    input  logic [DRP_AW-1:0] cmd_addr,
    input  logic [DRP_DW-1:0] cmd_data,
    input  logic              drp_rdy,
    input  logic [DRP_DW-1:0] drp_do,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    output logic              busy,
    output logic [DRP_DW-1:0] rd_data
);
    drp_state_e st_q, st_d;
    logic       accept;
    logic       finish;
    logic       we_q;

    assign accept = cmd_go && (st_q == ST_IDLE);
    assign finish = (st_q != ST_IDLE) && drp_rdy;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = ST_ISSUE;
            ST_ISSUE: st_d = drp_rdy ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (drp_rdy) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        drp_en = (st_q == ST_ISSUE);
        busy   = (st_q != ST_IDLE);
        drp_we = we_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            drp_addr <= '0;
            drp_di   <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                we_q     <= !cmd_read;
                drp_addr <= cmd_addr;
                drp_di   <= cmd_data;
            end
            if (finish && !we_q)
                rd_data <= drp_do;
        end
    end

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en);
    p_hold_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> ($stable(drp_addr) && $stable(drp_di) && $stable(drp_we)));
    p_busy_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go) |=> (busy && drp_en));
    p_rdy_clears_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && drp_rdy) |=> !busy);
    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_go) |=> (!drp_en && $stable(drp_addr) && $stable(drp_di)));
    p_idle_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && drp_rdy && !cmd_go) |=> (!busy && $stable(rd_data)));
endmodule

// File: rtl/drp_prim_ctl.sv
module drp_prim_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wbits,
    output logic [1:0] bits_q,
    output logic       prim_rst,
    output logic       prim_oe
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= 2'b00;
        else if (wr)
            bits_q <= wbits;
    end

    assign prim_rst = !bits_q[0];
    assign prim_oe  = bits_q[1];

    p_ctl_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (prim_rst == !$past(wbits[0]) && prim_oe == $past(wbits[1])));
endmodule

// File: rtl/drp_cfg_bridge.sv
module drp_cfg_bridge
    import drp_bridge_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int DRP_AW = 7,
    parameter int DRP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy,
    output logic              prim_rst,
    output logic              prim_oe
);
    logic              cmd_go, cmd_read, rstctl_wr, busy;
    logic [DRP_AW-1:0] cmd_addr;
    logic [DRP_DW-1:0] cmd_data, rd_data;
    logic [1:0]        rstctl_bits;

    drp_reg_decode #(.REG_AW(REG_AW), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
        .rd_data(rd_data), .rstctl_bits(rstctl_bits), .cmd_go(cmd_go),
        .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rstctl_wr(rstctl_wr), .reg_rdata(reg_rdata)
    );

    drp_txn_fsm #(.DRP_AW(DRP_AW), .DRP_DW(DRP_DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_read(cmd_read),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .drp_rdy(drp_rdy),
        .drp_do(drp_do), .drp_en(drp_en), .drp_we(drp_we),
        .drp_addr(drp_addr), .drp_di(drp_di), .busy(busy), .rd_data(rd_data)
    );

    drp_prim_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(rstctl_wr), .wbits(reg_wdata[1:0]),
        .bits_q(rstctl_bits), .prim_rst(prim_rst), .prim_oe(prim_oe)
    );

    p_reset_view_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!drp_en && prim_rst && !prim_oe));
endmodule

// File: tb/drp_cfg_bridge_bench.sv
module drp_cfg_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        drp_en, drp_we, drp_rdy = 1'b0;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di, drp_do = '0;
    logic        prim_rst, prim_oe;

    int checks = 0, failures = 0;
    int slave_lat = 0;
    bit spur_req = 0;
    bit done = 0;
    logic [15:0] mem [128];
    logic [23:0] exp_q [$];
    bit          in_txn = 0;
    logic [23:0] held;

    always #2 clk = ~clk;

    drp_cfg_bridge u_drp_cfg_bridge (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
        .drp_do(drp_do), .drp_rdy(drp_rdy), .prim_rst(prim_rst), .prim_oe(prim_oe)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'h3C00 ^ 16'(a * 16'h0107);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // port slave model
    always begin
        @(negedge clk);
        if (spur_req) begin
            drp_do = 16'hDEAD; drp_rdy = 1'b1; spur_req = 0;
            @(negedge clk); drp_rdy = 1'b0;
        end else if (rst_n && drp_en) begin
            automatic logic [6:0]  a = drp_addr;
            automatic logic        w = drp_we;
            automatic logic [15:0] d = drp_di;
            repeat (slave_lat) @(negedge clk);
            if (w) begin mem[a] = d; drp_do = 16'hBEEF; end
            else drp_do = mem[a];
            drp_rdy = 1'b1;
            @(negedge clk); drp_rdy = 1'b0;
        end
    end

    // scoreboard monitor
    always begin
        @(negedge clk); #1;
        if (rst_n) begin
            if (drp_en) begin
                if (exp_q.size() == 0)
                    chk(0, "R6/R7 unexpected strobe", {8'd0, drp_we, drp_addr, drp_di}, 32'd0);
                else begin
                    automatic logic [23:0] e = exp_q.pop_front();
                    chk({drp_we, drp_addr, drp_di} == e, "R2 strobe fields",
                        {8'd0, drp_we, drp_addr, drp_di}, {8'd0, e});
                end
                held = {drp_we, drp_addr, drp_di};
                in_txn = 1;
            end else if (in_txn) begin
                chk({drp_we, drp_addr, drp_di} == held, "R3 held fields",
                    {8'd0, drp_we, drp_addr, drp_di}, {8'd0, held});
            end
            if (in_txn && drp_rdy) in_txn = 0;
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; #1; v = reg_rdata;
    endtask

    function automatic logic [31:0] cmd(input bit rd, input logic [6:0] a, input logic [15:0] d);
        return (32'd1 << 29) | (32'(rd) << 28) | (32'(a) << 16) | 32'(d);
    endfunction

    task automatic launch(input bit rd, input logic [6:0] a, input logic [15:0] d, input int lat);
        slave_lat = lat;
        exp_q.push_back({!rd, a, d});
        reg_write(8'h70, cmd(rd, a, d));
        #1;
    endtask

    task automatic wait_idle(output logic [31:0] v);
        for (int i = 0; i < 50; i++) begin
            reg_read(8'h74, v);
            if (!v[16]) break;
        end
    endtask

    task automatic finish_up;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 128; i++) mem[i] = pat(i);
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1;
        chk(!drp_en, "R1 drp_en", 32'(drp_en), 0);
        chk(prim_rst, "R1 prim_rst", 32'(prim_rst), 1);
        chk(!prim_oe, "R1 prim_oe", 32'(prim_oe), 0);
        reg_read(8'h74, v); chk(v == 0, "R1 status", v, 0);
        reg_read(8'h40, v); chk(v == 0, "R1 rstctl", v, 0);

        // R2/R4/R5 port write
        launch(0, 7'h08, 16'h1234, 3);
        chk(drp_en && drp_we, "R2 strobe after write", {30'd0, drp_en, drp_we}, 32'd3);
        reg_read(8'h74, v); chk(v[16], "R4 busy set", v, 32'h0001_0000);
        wait_idle(v); chk(v == 0, "R5 write keeps data, R4 busy clear", v, 0);

        // R5 port read, zero latency
        launch(1, 7'h08, 16'h0000, 0);
        chk(drp_en && !drp_we, "R2 read strobe", {30'd0, drp_en, drp_we}, 32'd2);
        wait_idle(v); chk(v == 32'h0000_1234, "R5 read data", v, 32'h1234);

        // R7 ignored command bits
        slave_lat = 1;
        exp_q.push_back({1'b0, 7'h4E, 16'hFFFF});
        reg_write(8'h70, 32'hF000_0000 | (32'h1F << 23) | (32'h4E << 16) | 32'hFFFF);
        wait_idle(v); chk(v == {16'd0, pat('h4E)}, "R7 ignored bits read", v, {16'd0, pat('h4E)});

        // R7 no launch bit
        reg_write(8'h70, cmd(0, 7'h11, 16'h5555) & ~(32'd1 << 29));
        #1; chk(!drp_en, "R7 no strobe without go", 32'(drp_en), 0);
        reg_read(8'h74, v); chk(v == {16'd0, pat('h4E)}, "R7 status unchanged", v, {16'd0, pat('h4E)});
        chk(mem[7'h11] == pat('h11), "R7 port mem untouched", 32'(mem[7'h11]), 32'(pat('h11)));

        // R6 command while busy
        launch(0, 7'h20, 16'hA0A0, 6);
        reg_write(8'h70, cmd(0, 7'h33, 16'h0F0F));
        #1; chk(!drp_en && drp_addr == 7'h20 && drp_di == 16'hA0A0, "R6 ignored while busy",
                {8'd0, drp_en, drp_addr, drp_di}, {8'd0, 1'b0, 7'h20, 16'hA0A0});
        wait_idle(v); chk(v[16] == 0, "R6 completes", v, 0);
        chk(mem[7'h33] == pat('h33), "R6 no second write", 32'(mem[7'h33]), 32'(pat('h33)));

        // R6 collision: command in the ready cycle
        launch(1, 7'h20, 16'h0000, 2);
        @(negedge clk);
        reg_write(8'h70, cmd(1, 7'h44, 16'h0000));
        #1; chk(!drp_en, "R6 collision no strobe", 32'(drp_en), 0);
        wait_idle(v); chk(v == 32'h0000_A0A0, "R6 collision data", v, 32'hA0A0);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        // R9 spurious ready
        spur_req = 1;
        repeat (3) @(negedge clk);
        reg_read(8'h74, v); chk(v == 32'h0000_A0A0, "R9 idle ready ignored", v, 32'hA0A0);

        // R8 reset/enable register
        reg_write(8'h40, 32'hFFFF_FFF3); #1;
        chk(!prim_rst && prim_oe, "R8 release+enable", {30'd0, prim_rst, prim_oe}, 32'd1);
        reg_read(8'h40, v); chk(v == 3, "R8 readback", v, 3);
        reg_write(8'h40, 32'h1); #1;
        chk(!prim_rst && !prim_oe, "R8 release only", {30'd0, prim_rst, prim_oe}, 0);
        reg_write(8'h40, 32'h2); #1;
        chk(prim_rst && prim_oe, "R8 reset with oe", {30'd0, prim_rst, prim_oe}, 3);

        // R10 other reads
        reg_read(8'h70, v); chk(v == 0, "R10 command reads zero", v, 0);
        reg_read(8'h00, v); chk(v == 0, "R10 unmapped zero", v, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all strobes seen", exp_q.size(), 0);
        done = 1;
        finish_up();
    end
endmodule